// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt

This block raises a sticky interrupt flag when the level of an asynchronous comparator output changes with respect to the last level software observed. The raw comparator level first crosses into the clock domain through a short synchronizer. A sampling register then follows the synchronized level once per instruction cycle, on a phase-1 strobe. A snapshot register captures the synchronized level each time software reads or writes the comparator status register. The two registers are compared by exclusive-OR. A rising edge of that mismatch sets the flag.

The flag is sensitive to the edge of the mismatch, not to its level. Software can therefore clear the flag while the mismatch is still present without taking a second interrupt. The status access path and the flag clear independently. A status read re-arms detection by reloading the snapshot, so a later return of the comparator to its former level interrupts again. The interrupt request leaves the block gated by a local, a peripheral and a global enable. The flag itself is recorded whatever those enables hold.

Top module: `cmp_chg_irq`

## Requirements
- R1: While reset is applied, and on the first clock after it, `flag`, `irq` and `stat_level` are all 0.
- R2: `stat_level` shows the value `cmp_raw` held two clock edges earlier. This is the synchronized comparator level.
- R3: The sampling register loads the synchronized level only on a clock where `ph1_stb` is 1. A comparator change with `ph1_stb` held at 0 never sets the flag. The first strobe afterwards sets it one clock later.
- R4: A clock with `stat_rd` or `stat_wr` at 1 loads the snapshot with the synchronized level. The snapshot holds that value until the next such access or a reset.
- R5: The mismatch is snapshot XOR sample. The clock after the mismatch goes from 0 to 1, `flag` is 1. With `ph1_stb` at 1 every cycle, a change of `cmp_raw` reaches `flag` on the fourth clock edge.
- R6: Clearing the flag while the mismatch remains 1 leaves the flag at 0 for as long as the mismatch persists.
- R7: A status read or a status write with `ph1_stb` at 1 clears the mismatch. A later change of the comparator back to its earlier level then sets the flag again.
- R8: If the comparator returns to the snapshot level, the mismatch clears without setting the flag. A further change away from that level sets the flag again.
- R9: A clock with `flag_wr` at 1 loads `flag_wdata` into the flag. Writing 1 sets it and writing 0 clears it.
- R10: `irq` is 1 only when `flag`, `en_local`, `en_periph` and `en_global` are all 1. The flag still sets while any enable is 0.
- R11: When a mismatch rising edge falls in the same clock as a status read and a flag write of 0, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_raw | input | 1 | Asynchronous comparator output level |
| ph1_stb | input | 1 | Phase-1 strobe, once per instruction cycle |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe (implies a read) |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Value written to the flag |
| en_local | input | 1 | Comparator interrupt enable |
| en_periph | input | 1 | Peripheral interrupt enable |
| en_global | input | 1 | Global interrupt enable |
| stat_level | output | 1 | Synchronized comparator level, read back through the status register |
| flag | output | 1 | Sticky change-detect flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The assertions check four things on every cycle. A flag only rises after a mismatch edge or a write of 1. A rising mismatch edge is always followed by a set flag. Flag writes take effect unless an edge collides with them. A status access taken with a phase-1 strobe leaves no mismatch, and `irq` never asserts without the flag and all three enables. The bench scenarios are needed for the rest. They show the sampling register holding through strobe-free cycles, the snapshot being re-armed by a write, a return to the snapshot level passing silently, and the exact four-edge latency from comparator change to flag.

// File: rtl/cmp_chg_pkg.sv
package cmp_chg_pkg;

  // Stages in the comparator level synchronizer (minimum 2).
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  // Stages in the reset release synchronizer (minimum 2).
  localparam int unsigned RST_DEPTH_DEF  = 2;

  // Interrupt enable set: all three must be high for a request.
  typedef struct packed {
    logic glb;
    logic per;
    logic loc;
  } irq_en_t;

endpackage

// File: rtl/cmp_chg_rst_sync.sv
module cmp_chg_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[DEPTH-1];

endmodule

// File: rtl/cmp_chg_sync.sv
module cmp_chg_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] stg_q;
  logic [DEPTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/cmp_chg_mismatch.sv
module cmp_chg_mismatch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic samp_en,
  input  logic snap_en,
  output logic mism
);

  logic samp_q, samp_d;
  logic snap_q, snap_d;

  // Next-state: each register has an explicit load enable.
  always_comb begin
    samp_d = samp_q;
    snap_d = snap_q;
    if (samp_en) samp_d = lvl;
    if (snap_en) snap_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      snap_q <= snap_d;
    end
  end

  assign mism = samp_q ^ snap_q;

endmodule

// File: rtl/cmp_chg_flag.sv
module cmp_chg_flag
  import cmp_chg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mism,
  input  logic    wr_en,
  input  logic    wr_data,
  input  irq_en_t en,
  output logic    flag,
  output logic    irq
);

  logic mism_q;
  logic flag_q, flag_d;
  logic rise;

  assign rise = mism & ~mism_q;

  // A detected edge outranks a software write in the same cycle.
  always_comb begin
    flag_d = flag_q;
    if (rise) begin
      flag_d = 1'b1;
    end else if (wr_en) begin
      flag_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mism_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      mism_q <= mism;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & en.loc & en.per & en.glb;

endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
  import cmp_chg_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  parameter int unsigned RST_DEPTH  = RST_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  input  logic ph1_stb,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic flag_wr,
  input  logic flag_wdata,
  input  logic en_local,
  input  logic en_periph,
  input  logic en_global,
  output logic stat_level,
  output logic flag,
  output logic irq
);

  logic    rst_i;
  logic    lvl_sync;
  logic    mism;
  logic    snap_ld;
  irq_en_t en_all;

  // Every status write begins with a read, so both reload the snapshot.
  assign snap_ld = stat_rd | stat_wr;
  assign en_all  = '{glb: en_global, per: en_periph, loc: en_local};

  cmp_chg_rst_sync #(.DEPTH(RST_DEPTH)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_i)
  );

  cmp_chg_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .din   (cmp_raw),
    .dout  (lvl_sync)
  );

  cmp_chg_mismatch u_mm (
    .clk     (clk),
    .rst_n   (rst_i),
    .lvl     (lvl_sync),
    .samp_en (ph1_stb),
    .snap_en (snap_ld),
    .mism    (mism)
  );

  cmp_chg_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_i),
    .mism    (mism),
    .wr_en   (flag_wr),
    .wr_data (flag_wdata),
    .en      (en_all),
    .flag    (flag),
    .irq     (irq)
  );

  assign stat_level = lvl_sync;

endmodule

// File: rtl/cmp_chg_irq_chk.sv
module cmp_chg_irq_chk (
  input logic clk,
  input logic rst_i,
  input logic mism,
  input logic ph1_stb,
  input logic stat_rd,
  input logic stat_wr,
  input logic flag_wr,
  input logic flag_wdata,
  input logic en_local,
  input logic en_periph,
  input logic en_global,
  input logic flag,
  input logic irq
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_i |-> (!flag && !irq));

  a_r5_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(mism) |=> flag);

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(flag) |-> (($past(mism) && !$past(mism, 2)) || $past(flag_wr && flag_wdata)));

  a_r7_access_rearms: assert property (@(posedge clk) disable iff (!rst_i)
    ((stat_rd || stat_wr) && ph1_stb) |=> !mism);

  a_r9_write_one: assert property (@(posedge clk) disable iff (!rst_i)
    (flag_wr && flag_wdata) |=> flag);

  a_r9_write_zero: assert property (@(posedge clk) disable iff (!rst_i)
    (flag_wr && !flag_wdata && !(mism && !$past(mism))) |=> !flag);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_i)
    !flag |-> !irq);

  a_r10_irq_needs_enables: assert property (@(posedge clk) disable iff (!rst_i)
    !(en_local && en_periph && en_global) |-> !irq);

  a_r10_irq_when_all: assert property (@(posedge clk) disable iff (!rst_i)
    (flag && en_local && en_periph && en_global) |-> irq);

  a_r11_edge_beats_access: assert property (@(posedge clk) disable iff (!rst_i)
    (stat_rd && flag_wr && mism && !$past(mism)) |=> flag);

endmodule

bind cmp_chg_irq cmp_chg_irq_chk u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .mism       (mism),
  .ph1_stb    (ph1_stb),
  .stat_rd    (stat_rd),
  .stat_wr    (stat_wr),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .en_local   (en_local),
  .en_periph  (en_periph),
  .en_global  (en_global),
  .flag       (flag),
  .irq        (irq)
);

// File: tb/sim_cmp_chg_irq.sv
module sim_cmp_chg_irq;

  logic clk;
  logic rst_n;
  logic cmp_raw, ph1_stb, stat_rd, stat_wr, flag_wr, flag_wdata;
  logic en_local, en_periph, en_global;
  logic stat_level, flag, irq;

  int checks;
  int errors;
  bit done;

  cmp_chg_irq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_raw    (cmp_raw),
    .ph1_stb    (ph1_stb),
    .stat_rd    (stat_rd),
    .stat_wr    (stat_wr),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .en_local   (en_local),
    .en_periph  (en_periph),
    .en_global  (en_global),
    .stat_level (stat_level),
    .flag       (flag),
    .irq        (irq)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  int lvl_hist[$];
  int m_rst_cnt;
  int m_samp, m_snap, m_prev_diff, m_flag;

  initial begin
    lvl_hist = '{0, 0};
    m_rst_cnt = 0; m_samp = 0; m_snap = 0; m_prev_diff = 0; m_flag = 0;
  end

  always @(posedge clk) begin
    int seen;
    int diff;
    if (!rst_n || m_rst_cnt < 2) begin
      if (!rst_n) m_rst_cnt = 0;
      else        m_rst_cnt = m_rst_cnt + 1;
      lvl_hist = '{0, 0};
      m_samp = 0; m_snap = 0; m_prev_diff = 0; m_flag = 0;
    end else begin
      seen = lvl_hist[0];
      diff = (m_samp != m_snap) ? 1 : 0;
      if (diff == 1 && m_prev_diff == 0) m_flag = 1;
      else if (flag_wr) m_flag = flag_wdata ? 1 : 0;
      m_prev_diff = diff;
      if (ph1_stb) m_samp = seen;
      if (stat_rd || stat_wr) m_snap = seen;
      lvl_hist.push_back(cmp_raw ? 1 : 0);
      void'(lvl_hist.pop_front());
    end
  end

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    int exp_irq;
    if (!done) begin
      exp_irq = (m_flag == 1 && en_local && en_periph && en_global) ? 1 : 0;
      chk("R2 model stat_level", int'(stat_level), lvl_hist[0]);
      chk("R5 model flag", int'(flag), m_flag);
      chk("R10 model irq", int'(irq), exp_irq);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_flag();
    flag_wr = 1'b1; flag_wdata = 1'b0;
    cyc(1);
    flag_wr = 1'b0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors = errors + 1;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; cmp_raw = 1'b0; ph1_stb = 1'b0;
    stat_rd = 1'b0; stat_wr = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0;
    en_local = 1'b0; en_periph = 1'b0; en_global = 1'b0;
    cyc(3);
    chk("R1 flag in reset", int'(flag), 0);
    chk("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1; ph1_stb = 1'b1;
    cyc(1);
    chk("R1 flag after release", int'(flag), 0);
    chk("R1 stat_level after release", int'(stat_level), 0);
    cyc(3);

    // R2 + R5: latency of a comparator change
    cmp_raw = 1'b1;
    cyc(1); chk("R2 level one edge later", int'(stat_level), 0);
    cyc(1); chk("R2 level two edges later", int'(stat_level), 1);
    cyc(1); chk("R5 flag not yet at edge 3", int'(flag), 0);
    cyc(1); chk("R5 flag set at edge 4", int'(flag), 1);
    chk("R10 flag set while enables low, irq low", int'(irq), 0);

    // R6: clear while mismatch persists
    clear_flag();
    chk("R6 flag cleared", int'(flag), 0);
    cyc(5); chk("R6 no re-set on held mismatch", int'(flag), 0);

    // R8: return to snapshot level, then leave again
    cmp_raw = 1'b0;
    cyc(6); chk("R8 silent return", int'(flag), 0);
    cmp_raw = 1'b1;
    cyc(6); chk("R8 new change sets flag", int'(flag), 1);
    clear_flag();

    // R4 + R7: a read re-arms; return then interrupts
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    cyc(4); chk("R4 read snapshot clears mismatch", int'(flag), 0);
    cmp_raw = 1'b0;
    cyc(6); chk("R7 return after read sets flag", int'(flag), 1);
    clear_flag();

    // R7: a write re-arms too (snapshot now 0, level 0)
    stat_wr = 1'b1; cyc(1); stat_wr = 1'b0;
    cyc(3); chk("R7 write clears mismatch", int'(flag), 0);
    cmp_raw = 1'b1;
    cyc(6); chk("R7 change after write sets flag", int'(flag), 1);
    clear_flag();

    // R3: sampling held without strobe
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    ph1_stb = 1'b0; cmp_raw = 1'b0;
    cyc(8);
    chk("R3 level visible without strobe", int'(stat_level), 0);
    chk("R3 no flag without strobe", int'(flag), 0);
    ph1_stb = 1'b1;
    cyc(1); chk("R3 strobe loads sample", int'(flag), 0);
    cyc(1); chk("R3 flag one edge after strobe", int'(flag), 1);
    clear_flag();

    // R9: software writes
    flag_wr = 1'b1; flag_wdata = 1'b1; cyc(1); flag_wr = 1'b0;
    chk("R9 write 1 sets", int'(flag), 1);
    clear_flag();
    chk("R9 write 0 clears", int'(flag), 0);

    // R10: enable gating over all combinations
    flag_wr = 1'b1; flag_wdata = 1'b1; cyc(1); flag_wr = 1'b0;
    for (int k = 0; k < 8; k++) begin
      en_local = k[0]; en_periph = k[1]; en_global = k[2];
      cyc(1);
      chk("R10 irq gating", int'(irq), (k == 7) ? 1 : 0);
    end
    en_local = 1'b0; en_periph = 1'b0; en_global = 1'b0;
    clear_flag();

    // R11: edge collides with a read and a flag clear
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    cmp_raw = 1'b1;
    cyc(3);
    stat_rd = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
    cyc(1);
    stat_rd = 1'b0; flag_wr = 1'b0;
    chk("R11 edge wins collision", int'(flag), 1);
    cyc(4); chk("R11 flag stays set", int'(flag), 1);

    summary();
  end

endmodule